// File: doc/BRIEF.md
# Serial Frame Boundary Lock Detector

This block takes a serial bit stream, one bit per cycle in which a bit-step enable is high. The stream is made of 12-bit frames. Each frame has a start bit of 1, then ten data bits, then a stop bit of 0. The block has no knowledge of where a frame begins. It watches all twelve possible bit positions (phases) at once and counts, for each phase, how many consecutive frames have shown a 0-to-1 step at that phase. When exactly one phase has been stable long enough, the detector locks to it. From then on it cuts each frame out of the stream and presents its ten data bits with a one-cycle strobe.

A stream in which a second 0-to-1 step repeats at the same place in every frame could make the detector lock to the wrong phase. Such a stream holds lock off until the pattern changes. Once lock is held, only a run of missing boundaries at the locked phase releases it. The lock flag is active low. A separate drive flag tells downstream logic when the word and strobe outputs carry meaning. An output enable and an active-low power control gate the outputs.

Top module: `frame_lock_detector`

## Requirements
- R1: After reset, `lock_n` is 1, and `drive_en` and `word_vld` are 0.
- R2: A boundary is a received 0 followed at the next bit step by a 1. Lock (`lock_n` falling) happens at the bit step of the fifth consecutive boundary at the same phase, which closes four complete 12-bit frames. It happens in the cycle after that bit step, and never earlier.
- R3: Word bit i is the i-th bit received after the start bit; bit 0 is the first one received. `word_vld` pulses for one cycle after each start bit that closes a frame at the locked phase. The first strobe carries the frame that follows the start bit on which lock was taken.
- R4: While locked, a bit step at the locked phase that shows no boundary counts as a miss. `lock_n` rises in the cycle after the fourth consecutive miss, and `drive_en` falls at the same time.
- R5: A boundary at the locked phase clears the miss count. Three misses followed by a boundary keep the lock.
- R6: While hunting, lock is refused when any other phase also has at least four consecutive boundaries. When the rival phase misses, lock is taken at the next boundary of the remaining phase.
- R7: Once locked, a repeating extra 0-to-1 step inside the data does not drop lock, and its words are still delivered.
- R8: `word_vld` is 1 only when `lock_n` is 0 and `drive_en` is 1. `drive_en` is the registered AND of lock, `out_en` and `pwr_on`.
- R9: While `out_en` is 0, `drive_en` and `word_vld` stay 0. `lock_n` keeps following the lock state.
- R10: One cycle of `pwr_on` low drives `lock_n` to 1 and `drive_en` and `word_vld` to 0, and clears all boundary history. After `pwr_on` returns to 1, the block hunts from phase 0.
- R11: Cycles with `bit_en` low change neither the lock state nor the word path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-step enable; `ser_in` is taken when high |
| ser_in | input | 1 | Serial data bit |
| out_en | input | 1 | Output enable for word and strobe |
| pwr_on | input | 1 | Active-low power down; low clears all state |
| lock_n | output | 1 | Lock flag, low while locked |
| word_out | output | DATA_W | Extracted data word, bit 0 received first |
| word_vld | output | 1 | One-cycle strobe for `word_out` |
| drive_en | output | 1 | High while word and strobe carry meaning |

## Verification
The properties assume that `lock_n` only falls on a bit step that carries a 1. They also assume that outputs only change on a bit step, or one cycle after `out_en` or `pwr_on` changes. Both hold only if the inputs are constant between clock edges. The bench therefore changes `ser_in`, `bit_en`, `out_en` and `pwr_on` only on falling clock edges. It keeps every frame phase-continuous, so idle cycles without a bit step never shift the frame grid. Data words are made of leading ones followed by zeros in transmit order, so they carry no internal 0-to-1 step. The only exception is the pattern that is deliberately ambiguous.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } lock_state_e;
endpackage

// File: rtl/fbl_bit_window.sv
// Serial history window plus the free-running frame phase.
module fbl_bit_window #(
  parameter int FRAME_W = 12,
  parameter int PH_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               bit_en,
  input  logic               ser_in,
  output logic [FRAME_W-1:0] win_nxt,
  output logic [PH_W-1:0]    phase,
  output logic               edge_hit
);
  logic [FRAME_W-1:0] sh_q;

  // window as it will look after this bit is taken; [0] is newest
  assign win_nxt  = {sh_q[FRAME_W-2:0], ser_in};
  assign edge_hit = ~sh_q[0] & ser_in;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q  <= '0;
      phase <= '0;
    end else if (bit_en) begin
      sh_q  <= win_nxt;
      phase <= (phase == PH_W'(FRAME_W-1)) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/fbl_phase_tracker.sv
// One saturating run counter per candidate boundary phase.
module fbl_phase_tracker #(
  parameter int FRAME_W     = 12,
  parameter int PH_W        = 4,
  parameter int LOCK_FRAMES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               bit_en,
  input  logic               edge_hit,
  input  logic [PH_W-1:0]    phase,
  output logic [FRAME_W-1:0] full
);
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1);

  for (genvar g = 0; g < FRAME_W; g++) begin : g_phase
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        run_q <= '0;
      end else if (bit_en && (phase == PH_W'(g))) begin
        if (!edge_hit)
          run_q <= '0;
        else if (run_q != CNT_W'(LOCK_FRAMES))
          run_q <= run_q + 1'b1;
      end
    end

    assign full[g] = (run_q == CNT_W'(LOCK_FRAMES));
  end
endmodule

// File: rtl/fbl_lock_ctrl.sv
// Hunt/track state, locked phase and consecutive-miss count.
module fbl_lock_ctrl
  import frame_lock_pkg::*;
#(
  parameter int FRAME_W     = 12,
  parameter int PH_W        = 4,
  parameter int LOSS_FRAMES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               bit_en,
  input  logic               edge_hit,
  input  logic [PH_W-1:0]    phase,
  input  logic [FRAME_W-1:0] full,
  output logic               locked,
  output logic               lock_nx,
  output logic               hit_word
);
  localparam int MISS_W = $clog2(LOSS_FRAMES + 1);

  lock_state_e        st_q, st_d;
  logic [PH_W-1:0]    lock_ph_q, lock_ph_d;
  logic [MISS_W-1:0]  miss_q, miss_d;
  logic [FRAME_W-1:0] own_mask;
  logic               rival, own_full, on_ph;

  assign locked = (st_q == ST_TRACK);

  always_comb begin
    own_mask  = FRAME_W'(1) << phase;
    own_full  = |(full & own_mask);
    rival     = |(full & ~own_mask);
    on_ph     = bit_en && (phase == lock_ph_q);
    st_d      = st_q;
    lock_ph_d = lock_ph_q;
    miss_d    = miss_q;
    hit_word  = 1'b0;
    if (clr) begin
      st_d   = ST_HUNT;
      miss_d = '0;
    end else if (st_q == ST_HUNT) begin
      // fifth boundary at this phase, and no other phase as strong
      if (bit_en && edge_hit && own_full && !rival) begin
        st_d      = ST_TRACK;
        lock_ph_d = phase;
        miss_d    = '0;
      end
    end else if (on_ph) begin
      if (edge_hit) begin
        miss_d   = '0;
        hit_word = 1'b1;
      end else if (miss_q == MISS_W'(LOSS_FRAMES - 1)) begin
        st_d   = ST_HUNT;
        miss_d = '0;
      end else begin
        miss_d = miss_q + 1'b1;
      end
    end
    lock_nx = (st_d == ST_TRACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      lock_ph_q <= '0;
      miss_q    <= '0;
    end else begin
      st_q      <= st_d;
      lock_ph_q <= lock_ph_d;
      miss_q    <= miss_d;
    end
  end
endmodule

// File: rtl/frame_lock_detector.sv
module frame_lock_detector #(
  parameter int DATA_W      = 10,
  parameter int LOCK_FRAMES = 4,
  parameter int LOSS_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              ser_in,
  input  logic              out_en,
  input  logic              pwr_on,
  output logic              lock_n,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld,
  output logic              drive_en
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int PH_W    = $clog2(FRAME_W);

  logic               clr;
  logic [FRAME_W-1:0] win_nxt;
  logic [PH_W-1:0]    phase;
  logic               edge_hit;
  logic [FRAME_W-1:0] full;
  logic               locked, lock_nx, hit_word;
  logic [DATA_W-1:0]  word_bits;

  assign clr = ~pwr_on;

  fbl_bit_window #(.FRAME_W(FRAME_W), .PH_W(PH_W)) u_window (
    .clk(clk), .rst(rst), .clr(clr), .bit_en(bit_en), .ser_in(ser_in),
    .win_nxt(win_nxt), .phase(phase), .edge_hit(edge_hit)
  );

  fbl_phase_tracker #(.FRAME_W(FRAME_W), .PH_W(PH_W), .LOCK_FRAMES(LOCK_FRAMES)) u_tracker (
    .clk(clk), .rst(rst), .clr(clr), .bit_en(bit_en), .edge_hit(edge_hit),
    .phase(phase), .full(full)
  );

  fbl_lock_ctrl #(.FRAME_W(FRAME_W), .PH_W(PH_W), .LOSS_FRAMES(LOSS_FRAMES)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .bit_en(bit_en), .edge_hit(edge_hit),
    .phase(phase), .full(full), .locked(locked), .lock_nx(lock_nx), .hit_word(hit_word)
  );

  // win_nxt[0] is the new start bit, [1] the stop bit, [FRAME_W-1] data bit 0
  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign word_bits[i] = win_nxt[FRAME_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_n   <= 1'b1;
      drive_en <= 1'b0;
      word_vld <= 1'b0;
      word_out <= '0;
    end else begin
      lock_n   <= ~lock_nx;
      drive_en <= lock_nx & out_en & pwr_on;
      word_vld <= hit_word & out_en & pwr_on;
      if (hit_word)
        word_out <= word_bits;
    end
  end
endmodule

// File: rtl/fbl_checker.sv
module fbl_checker (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic ser_in,
  input logic out_en,
  input logic pwr_on,
  input logic lock_n,
  input logic word_vld,
  input logic drive_en
);
  p_lock_on_one_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n) |-> ($past(bit_en) && $past(ser_in)));

  p_loss_on_step_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(lock_n) && $past(pwr_on)) |-> $past(bit_en));

  p_strobe_locked_r8: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (!lock_n && drive_en));

  p_drive_locked_r8: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> !lock_n);

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (!drive_en && !word_vld));

  p_pd_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> (lock_n && !drive_en && !word_vld));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && pwr_on) |=> ($stable(lock_n) && !word_vld));
endmodule

bind frame_lock_detector fbl_checker i_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .out_en(out_en),
  .pwr_on(pwr_on), .lock_n(lock_n), .word_vld(word_vld), .drive_en(drive_en)
);

// File: tb/test_frame_lock_detector.sv
module test_frame_lock_detector;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam logic [DW-1:0] RMT_WORD = 10'h020; // D4=0, D5=1: extra 0-to-1 step

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, ser_in = 1'b0, out_en = 1'b1, pwr_on = 1'b1;
  logic lock_n, word_vld, drive_en;
  logic [DW-1:0] word_out;

  int n_chk = 0, n_fail = 0, ncap = 0;
  logic [DW-1:0] cap [0:63];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_lock_detector i_frame_lock_detector (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .out_en(out_en),
    .pwr_on(pwr_on), .lock_n(lock_n), .word_out(word_out), .word_vld(word_vld),
    .drive_en(drive_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe monitor: record words, and check R8 at every strobe
  always @(negedge clk) begin
    if (!rst && word_vld) begin
      chk("R8 strobe while locked and driven", {30'd0, lock_n, drive_en}, 32'd1);
      if (ncap < 64) cap[ncap] = word_out;
      ncap++;
    end
  end

  function automatic logic [DW-1:0] ramp(input int k);
    logic [DW:0] t;
    t = (11'd1 << k) - 11'd1;
    return t[DW-1:0];
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_in = b;
    bit_en = 1'b1;
  endtask

  task automatic send_bit_gap(input logic b);
    send_bit(b);
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_body(input logic [DW-1:0] w, input bit gaps = 1'b0);
    for (int i = 0; i < DW; i++) begin
      if (gaps) send_bit_gap(w[i]); else send_bit(w[i]);
    end
    if (gaps) send_bit_gap(1'b0); else send_bit(1'b0);
  endtask

  task automatic send_frame(input logic [DW-1:0] w);
    send_bit(1'b1);
    send_body(w);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic settle();
    @(negedge clk);
    bit_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R1 lock_n after reset", lock_n, 1);
    chk("R1 drive_en after reset", drive_en, 0);
    chk("R1 word_vld after reset", word_vld, 0);
  endtask

  task automatic t_acquire();
    for (int k = 1; k <= 4; k++) send_frame(ramp(k));
    settle();
    chk("R2 no lock after four boundaries", lock_n, 1);
    chk("R2 no strobe while hunting", ncap, 0);
    send_bit(1'b1);
    settle();
    chk("R2 lock at fifth boundary", lock_n, 0);
    chk("R8 drive with lock", drive_en, 1);
    ncap = 0;
    send_body(ramp(5));
    send_bit(1'b1);
    send_body(ramp(6));
    send_bit(1'b1);
    settle();
    chk("R3 strobe count", ncap, 2);
    chk("R3 first word order", cap[0], ramp(5));
    chk("R3 second word order", cap[1], ramp(6));
  endtask

  task automatic t_gaps();
    ncap = 0;
    send_body(ramp(7), 1'b1);
    send_bit(1'b1);
    settle();
    chk("R11 lock kept over idle cycles", lock_n, 0);
    chk("R11 one strobe over idle cycles", ncap, 1);
    chk("R11 word intact over idle cycles", cap[0], ramp(7));
  endtask

  task automatic t_out_enable();
    out_en = 1'b0;
    ncap = 0;
    send_body(ramp(8));
    send_bit(1'b1);
    settle();
    chk("R9 drive off", drive_en, 0);
    chk("R9 no strobe", ncap, 0);
    chk("R9 lock still reported", lock_n, 0);
    out_en = 1'b1;
    send_body(ramp(9));
    send_bit(1'b1);
    settle();
    chk("R9 strobe resumes", ncap, 1);
    chk("R9 word after enable", cap[0], ramp(9));
    chk("R9 drive back on", drive_en, 1);
  endtask

  task automatic t_loss();
    send_body(ramp(10));
    send_zeros(36);
    settle();
    chk("R5 three misses keep lock", lock_n, 0);
    send_bit(1'b1);
    settle();
    chk("R5 match clears misses", lock_n, 0);
    send_body(ramp(2));
    send_zeros(36);
    settle();
    chk("R4 lock after three misses", lock_n, 0);
    send_bit(1'b0);
    settle();
    chk("R4 lock lost on fourth miss", lock_n, 1);
    chk("R4 drive off after loss", drive_en, 0);
    send_zeros(11);
  endtask

  task automatic t_ambiguous();
    for (int f = 0; f < 8; f++) send_frame(RMT_WORD);
    settle();
    chk("R6 ambiguous pattern holds lock off", lock_n, 1);
    send_frame(ramp(3));
    settle();
    chk("R6 rival still full at next boundary", lock_n, 1);
    send_bit(1'b1);
    settle();
    chk("R6 lock after rival misses", lock_n, 0);
  endtask

  task automatic t_locked_repeat();
    ncap = 0;
    for (int f = 0; f < 5; f++) begin
      send_body(RMT_WORD);
      send_bit(1'b1);
    end
    settle();
    chk("R7 lock kept under repeating steps", lock_n, 0);
    chk("R7 words delivered", ncap, 5);
    chk("R7 word value", cap[4], RMT_WORD);
  endtask

  task automatic t_power_down();
    @(negedge clk);
    pwr_on = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 lock_n high in power down", lock_n, 1);
    chk("R10 drive off in power down", drive_en, 0);
    chk("R10 no strobe in power down", word_vld, 0);
    @(negedge clk);
    pwr_on = 1'b1;
    for (int k = 0; k < 4; k++) send_frame(ramp(k + 4));
    settle();
    chk("R10 history cleared", lock_n, 1);
    send_bit(1'b1);
    settle();
    chk("R10 relock from phase 0", lock_n, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_gaps();
    t_out_enable();
    t_loss();
    t_ambiguous();
    t_locked_repeat();
    t_power_down();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule